// File: doc/BRIEF.md
# Bus Reset and Presence Detector

This block handles the reset phase of a single-channel one-wire bus master. A one-cycle command strobe starts a reset slot. The block pulls the bus low through an open-drain enable for a programmable number of clocks, then releases it. After release it samples the synchronized line twice. The first sample, taken early, looks for a bus that is stuck low. The second sample, taken later, looks for a slave device answering with a low pulse.

The results are kept in a byte-wide status word that the host reads directly. The word holds a busy bit, a presence bit, a short bit, a live line-level bit and a device-reset bit. The line-level bit is refreshed only when the host starts a status read, and that read never causes bus activity. The device-reset bit is set by power-on or by a soft reset, and a configuration write clears it.

All timing points are parameters in system clocks, each measured from the first clock of the low pulse. They must keep the order low time < short instant < presence instant < slot length. The raw bus input goes through a two-stage synchronizer, and both sample instants see the bus as it was about two clocks earlier.

Top module: `owire_reset_presence`

## Requirements
- R1: The status word uses these bit positions: bit 0 is busy, bit 1 is presence, bit 2 is short, bit 3 is line level, bit 4 is device reset. Bits 7 to 5 belong to commands outside this block and always read 0.
- R2: After `rst_n` is released, or in the clock after a `soft_reset` strobe, status reads 8'h10 and `bus_drive_low` is 0. A `soft_reset` aborts any slot in progress.
- R3: A `cfg_write` strobe clears bit 4 and leaves every other status bit unchanged.
- R4: A `cmd_reset` strobe while idle starts a slot in the next clock. `bus_drive_low` is then 1 for exactly T_LOW clocks, and busy is 1 for exactly T_SLOT clocks.
- R5: A `cmd_reset` strobe while busy is 1 is ignored, and the running slot ends at its original time.
- R6: At the short instant, bit 2 becomes 1 if the synchronized line is low and 0 if it is high. A short is therefore cleared by a later slot once the line is free.
- R7: At the presence instant, bit 1 becomes 1 only if the line is low and bit 2 is 0. Whenever bit 2 is 1, bit 1 is 0.
- R8: A `stat_rd` strobe copies the synchronized line into bit 3. At all other times bit 3 holds its value. A status read drives nothing onto the bus and does not set busy.
- R9: Outside a slot, the presence, short and device-reset bits do not change when the bus changes. Only `cfg_write` and `soft_reset` can alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| soft_reset | input | 1 | Commanded device reset strobe |
| cmd_reset | input | 1 | Start a bus reset slot (strobe) |
| cfg_write | input | 1 | Host configuration write strobe |
| stat_rd | input | 1 | Host begins a status read (strobe) |
| bus_in | input | 1 | Raw bus level, asynchronous |
| bus_drive_low | output | 1 | Open-drain enable; 1 pulls the bus low |
| status | output | 8 | Status word |

## Verification
The bench builds the block with T_LOW=20, T_SHORT=26, T_PRES=40 and T_SLOT=60. These values fit a whole slot into a few dozen clocks, so every scenario runs many slots. The two sample instants sit far enough apart that a modelled slave pulse can land clearly between them, clearly before them, or not at all. Because of these margins, the exact-length pulse and busy windows can be counted cycle by cycle, and the two-flop synchronizer delay never makes a sample ambiguous.

// File: rtl/owpd_pkg.sv
package owpd_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_PPD  = 1;
  localparam int ST_SD   = 2;
  localparam int ST_LL   = 3;
  localparam int ST_RST  = 4;
  localparam logic [7:0] ST_AFTER_RESET = 8'h10;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_LOW     = 2'd1,
    SQ_RECOVER = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic dir;
    logic tsb;
    logic sbr;
    logic rst;
    logic ll;
    logic sd;
    logic ppd;
    logic busy;
  } status_t;
endpackage

// File: rtl/owpd_sync.sv
module owpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/owpd_seq.sv
module owpd_seq
  import owpd_pkg::*;
#(
  parameter int T_LOW   = 24000,
  parameter int T_SHORT = 24400,
  parameter int T_PRES  = 27500,
  parameter int T_SLOT  = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic drive_low,
  output logic smp_short,
  output logic smp_pres
);
  localparam int CW = $clog2(T_SLOT + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(T_LOW - 1);
  localparam logic [CW-1:0] SLOT_LAST = CW'(T_SLOT - 1);
  localparam logic [CW-1:0] AT_SHORT  = CW'(T_SHORT);
  localparam logic [CW-1:0] AT_PRES   = CW'(T_PRES);

  seq_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else if (abort) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (start) state <= SQ_LOW;
        end
        SQ_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == LOW_LAST) state <= SQ_RECOVER;
        end
        SQ_RECOVER: begin
          if (cnt == SLOT_LAST) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= SQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy      = (state != SQ_IDLE);
  assign drive_low = (state == SQ_LOW);
  assign smp_short = (state == SQ_RECOVER) && (cnt == AT_SHORT);
  assign smp_pres  = (state == SQ_RECOVER) && (cnt == AT_PRES);
endmodule

// File: rtl/owpd_status.sv
module owpd_status
  import owpd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    soft_rst,
  input  logic    cfg_write,
  input  logic    stat_rd,
  input  logic    line,
  input  logic    busy,
  input  logic    smp_short,
  input  logic    smp_pres,
  output status_t stat
);
  logic f_rst, f_ll, f_sd, f_ppd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_rst <= 1'b1;
      f_ll  <= 1'b0;
      f_sd  <= 1'b0;
      f_ppd <= 1'b0;
    end else if (soft_rst) begin
      f_rst <= 1'b1;
      f_ll  <= 1'b0;
      f_sd  <= 1'b0;
      f_ppd <= 1'b0;
    end else begin
      if (cfg_write) f_rst <= 1'b0;
      if (stat_rd)   f_ll  <= line;
      if (smp_short) begin
        f_sd <= ~line;
        if (!line) f_ppd <= 1'b0;
      end
      if (smp_pres) f_ppd <= ~line & ~f_sd;
    end
  end

  always_comb begin
    stat      = '0;
    stat.busy = busy;
    stat.ppd  = f_ppd;
    stat.sd   = f_sd;
    stat.ll   = f_ll;
    stat.rst  = f_rst;
  end
endmodule

// File: rtl/owire_reset_presence.sv
module owire_reset_presence
  import owpd_pkg::*;
#(
  parameter int T_LOW       = 24000,
  parameter int T_SHORT     = 24400,
  parameter int T_PRES      = 27500,
  parameter int T_SLOT      = 48000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_reset,
  input  logic       cmd_reset,
  input  logic       cfg_write,
  input  logic       stat_rd,
  input  logic       bus_in,
  output logic       bus_drive_low,
  output logic [7:0] status
);
  logic    line_s;
  logic    busy, smp_short, smp_pres;
  status_t stat;

  owpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (bus_in),
    .q_sync  (line_s)
  );

  owpd_seq #(
    .T_LOW   (T_LOW),
    .T_SHORT (T_SHORT),
    .T_PRES  (T_PRES),
    .T_SLOT  (T_SLOT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (soft_reset),
    .start     (cmd_reset),
    .busy      (busy),
    .drive_low (bus_drive_low),
    .smp_short (smp_short),
    .smp_pres  (smp_pres)
  );

  owpd_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_reset),
    .cfg_write (cfg_write),
    .stat_rd   (stat_rd),
    .line      (line_s),
    .busy      (busy),
    .smp_short (smp_short),
    .smp_pres  (smp_pres),
    .stat      (stat)
  );

  assign status = stat;
endmodule

// File: rtl/owpd_checker.sv
module owpd_checker
  import owpd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       soft_reset,
  input logic       cmd_reset,
  input logic       cfg_write,
  input logic       stat_rd,
  input logic       bus_drive_low,
  input logic [7:0] status
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000); // R1

  AST_SOFT_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (status == ST_AFTER_RESET) && !bus_drive_low); // R2

  AST_CFG_CLEARS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_write && !soft_reset) |=> !status[ST_RST]); // R3

  AST_DRIVE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_low |-> status[ST_BUSY]); // R4

  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_BUSY]) |-> $past(cmd_reset)); // R5

  AST_SHORT_KILLS_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_SD] |-> !status[ST_PPD]); // R7

  AST_LL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stat_rd) && !$past(soft_reset)) |-> $stable(status[ST_LL])); // R8

  AST_IDLE_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[ST_BUSY] && !$past(status[ST_BUSY]) && !$past(soft_reset))
      |-> $stable(status[ST_SD:ST_PPD])); // R9
endmodule

bind owire_reset_presence owpd_checker i_owpd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_reset    (soft_reset),
  .cmd_reset     (cmd_reset),
  .cfg_write     (cfg_write),
  .stat_rd       (stat_rd),
  .bus_drive_low (bus_drive_low),
  .status        (status)
);

// File: tb/test_owire_reset_presence.sv
`timescale 1ns/1ps
module test_owire_reset_presence;
  localparam int TL = 20, TS = 26, TP = 40, TSL = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_reset = 1'b0, cmd_reset = 1'b0, cfg_write = 1'b0, stat_rd = 1'b0;
  logic dev_pull = 1'b0, bus_short = 1'b0;
  logic bus_in, bus_drive_low;
  logic [7:0] status;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign bus_in = !(bus_drive_low || dev_pull || bus_short);

  owire_reset_presence #(.T_LOW(TL), .T_SHORT(TS), .T_PRES(TP), .T_SLOT(TSL)) i_owire_reset_presence (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .cmd_reset(cmd_reset),
    .cfg_write(cfg_write), .stat_rd(stat_rd), .bus_in(bus_in),
    .bus_drive_low(bus_drive_low), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // Runs one slot; slave pulls low in cycles 30..49 if present.
  task automatic run_slot(input bit present, input bit poke_busy,
                          output int low_cnt, output int busy_cnt);
    low_cnt = 0; busy_cnt = 0;
    @(negedge clk); cmd_reset = 1'b1;
    for (int k = 1; k <= TSL + 4; k++) begin
      @(negedge clk);
      cmd_reset = (poke_busy && k == 10);
      if (bus_drive_low) low_cnt++;
      if (status[0]) busy_cnt++;
      dev_pull = present && (k >= 30) && (k < 50);
    end
    dev_pull = 1'b0; cmd_reset = 1'b0;
  endtask

  task automatic t_reset_state;
    check("R2 status after power-on", status, 8'h10);
    check("R2 drive after power-on", bus_drive_low, 0);
    check("R1 upper bits", status[7:5], 0);
  endtask

  task automatic t_cfg_clear;
    strobe(cfg_write);
    @(negedge clk);
    check("R3 cfg clears rst", status, 8'h00);
  endtask

  task automatic t_present;
    int lc, bc;
    run_slot(1'b1, 1'b0, lc, bc);
    check("R4 low pulse length", lc, TL);
    check("R4 busy length", bc, TSL);
    check("R7 presence seen", status & 8'hF7, 8'h02);
  endtask

  task automatic t_absent;
    int lc, bc;
    run_slot(1'b0, 1'b0, lc, bc);
    check("R7 no presence", status & 8'hF7, 8'h00);
  endtask

  task automatic t_short;
    int lc, bc;
    bus_short = 1'b1;
    run_slot(1'b1, 1'b0, lc, bc);
    check("R6 short flagged, R7 presence forced 0", status & 8'hF7, 8'h04);
    bus_short = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 short held while idle", status & 8'hF7, 8'h04);
    run_slot(1'b1, 1'b0, lc, bc);
    check("R6 short cleared after removal", status & 8'hF7, 8'h02);
  endtask

  task automatic t_busy_ignore;
    int lc, bc;
    run_slot(1'b1, 1'b1, lc, bc);
    check("R5 busy length with extra cmd", bc, TSL);
    check("R5 low length with extra cmd", lc, TL);
  endtask

  task automatic t_level;
    bus_short = 1'b1;
    repeat (4) @(negedge clk);
    strobe(stat_rd);
    check("R8 level low captured", status[3], 0);
    check("R8 read starts no activity", {bus_drive_low, status[0]}, 0);
    bus_short = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 level held without read", status[3], 0);
    strobe(stat_rd);
    check("R8 level high captured", status[3], 1);
  endtask

  task automatic t_idle_stable;
    int lc, bc;
    run_slot(1'b1, 1'b0, lc, bc);
    dev_pull = 1'b1;
    repeat (5) @(negedge clk);
    dev_pull = 1'b0;
    bus_short = 1'b1;
    repeat (5) @(negedge clk);
    bus_short = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 flags stable while idle", status & 8'hF7, 8'h02);
  endtask

  task automatic t_soft_reset;
    @(negedge clk); cmd_reset = 1'b1;
    @(negedge clk); cmd_reset = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 slot running before abort", {bus_drive_low, status[0]}, 2'b11);
    soft_reset = 1'b1;
    @(negedge clk); soft_reset = 1'b0;
    check("R2 soft reset status", status, 8'h10);
    check("R2 soft reset releases bus", bus_drive_low, 0);
    strobe(cfg_write);
    @(negedge clk);
    check("R3 rst cleared again", status[4], 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_cfg_clear();
        t_present();
        t_absent();
        t_short();
        t_busy_ignore();
        t_level();
        t_idle_stable();
        t_soft_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule